// File: doc/BRIEF.md
# Scrolling Spectrogram Column Display Engine

This block paints a scrolling spectrogram onto a raster display. It holds a fixed number of intensity columns, each `ROWS` bytes tall, in a circular column store. A separate timing generator supplies the current pixel coordinates and a one-cycle frame-start pulse. Fresh spectral columns arrive over a 32-bit first-word-fall-through FIFO link, four 8-bit intensities packed in each word.

A three-state controller sequences the work. It idles until a frame starts, then paints pixels while the raster is inside the active area. When the raster moves below the last active line, it pulls exactly one new column from the link, and then returns to idle. The new column is placed just left of the newest one by stepping a first-column pointer back by one. Old columns scroll to the right without any data being copied. Intensities are shown as grey by copying the byte onto all three colour channels.

Top module: `spectro_scroll`

## Requirements
- R1: After reset the controller is idle, the first-column pointer is 0, `rgb` is 0 and `link_read` is 0.
- R2: While idle, `rgb` is black and the controller stays idle until `frame_start` is sampled high, which moves it to the drawing state.
- R3: While drawing, `rgb` is updated one clock after the coordinates are sampled. It is `{p,p,p}`, where `p` is the stored byte at row `px_y` of stored column `(first + px_x) mod COLS`.
- R4: While drawing, `rgb` is black whenever `px_x >= COLS`, `px_y >= ROWS`, `px_x >= ACT_W` or `px_y >= ACT_H`.
- R5: The drawing state is left for the loading state when `px_y >= ACT_H` is sampled. `rgb` is black in the loading state.
- R6: In the loading state each word is unpacked least significant byte first. Bits [8b+7:8b] of word k go to row 4k+b, one byte per clock. `link_read` is high in the cycle that writes byte 3, so a full column uses ROWS valid cycles and ROWS/4 pops.
- R7: While `link_valid` is low in the loading state, nothing is written, `link_read` stays 0 and the controller waits. `link_read` is never high without `link_valid`.
- R8: A new column is written to stored column `(first - 1) mod COLS`. The pointer takes that value once the column is complete, so `px_x = 0` shows the newest column and `px_x = 1` the one before. The pointer wraps around the store.
- R9: After the pop of the last word of a column, the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| px_x | input | XW | Current raster column |
| px_y | input | YW | Current raster line |
| link_data | input | 32 | Head word of the column FIFO |
| link_valid | input | 1 | FIFO holds a word |
| link_read | output | 1 | Pops the head word at this clock edge |
| rgb | output | 24 | Grey pixel, {red, green, blue} |

## Verification
A coordinate driven between edges shows up on `rgb` after the next rising edge. The bench sets coordinates on a falling edge and compares a full cycle later, on the following falling edge. `link_read` is combinational from the current byte phase, so the bench reads it just after presenting a word and before the edge that consumes it. It counts valid cycles and pops per column against ROWS and ROWS/4. The return to idle is checked on the first probe after the final pop: with no frame pulse, the probe must read black. Each scrolled column is then checked on the frame that follows its load.

// File: rtl/spectro_scroll.sv
module spectro_scroll #(
  parameter int XW    = 10,
  parameter int YW    = 10,
  parameter int ACT_W = 640,
  parameter int ACT_H = 480,
  parameter int COLS  = 8,
  parameter int ROWS  = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [XW-1:0] px_x,
  input  logic [YW-1:0] px_y,
  input  logic [31:0]   link_data,
  input  logic          link_valid,
  output logic          link_read,
  output logic [23:0]   rgb
);
  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int WPC    = ROWS / 4;
  localparam int WCNT_W = ROW_W - 2;
  localparam int DEPTH  = COLS * ROWS;
  localparam logic [XW-1:0]     ACT_W_L = XW'(ACT_W);
  localparam logic [YW-1:0]     ACT_H_L = YW'(ACT_H);
  localparam logic [XW-1:0]     COLS_L  = XW'(COLS);
  localparam logic [YW-1:0]     ROWS_L  = YW'(ROWS);
  localparam logic [WCNT_W-1:0] WLAST   = WCNT_W'(WPC - 1);

  typedef enum logic [1:0] {IDLE = 2'd0, DRAW = 2'd1, LOAD = 2'd2} st_t;

  st_t               st;
  logic [COL_W-1:0]  first;
  logic [WCNT_W-1:0] wcnt;
  logic [1:0]        phase;
  logic [7:0]        mem [DEPTH];

  wire               visible = (px_x < ACT_W_L) && (px_y < ACT_H_L);
  wire               stored  = (px_x < COLS_L) && (px_y < ROWS_L);
  wire [COL_W-1:0]   rd_col  = first + px_x[COL_W-1:0];
  wire [COL_W-1:0]   new_col = first - 1'b1;
  wire [COL_W+ROW_W-1:0] rd_addr = {rd_col, px_y[ROW_W-1:0]};
  wire [COL_W+ROW_W-1:0] wr_addr = {new_col, wcnt, phase};
  wire [7:0]         rd_pix  = mem[rd_addr];
  wire [7:0]         wr_byte = link_data[8*phase +: 8];
  wire               wr_en   = (st == LOAD) && link_valid;

  assign link_read = wr_en && (phase == 2'd3);

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      first <= '0;
      wcnt  <= '0;
      phase <= '0;
      rgb   <= '0;
    end else begin
      rgb <= (st == DRAW && visible && stored) ? {3{rd_pix}} : 24'd0;
      case (st)
        IDLE: if (frame_start) st <= DRAW;
        DRAW: if (px_y >= ACT_H_L) st <= LOAD;
        LOAD: if (link_valid) begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            if (wcnt == WLAST) begin
              wcnt  <= '0;
              first <= new_col;
              st    <= IDLE;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spectro_scroll_chk.sv
module spectro_scroll_chk #(
  parameter int COL_W  = 3,
  parameter int WCNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              link_valid,
  input logic              link_read,
  input logic [1:0]        st,
  input logic [COL_W-1:0]  first,
  input logic [WCNT_W-1:0] wcnt,
  input logic [1:0]        phase
);
  localparam logic [WCNT_W-1:0] WLAST = '1;

  a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    link_read |-> link_valid);

  a_r6_pop_gap: assert property (@(posedge clk) disable iff (!rst_n)
    link_read |=> !link_read);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !link_valid) |=> ($stable(wcnt) && $stable(phase) && st == 2'd2));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !frame_start) |=> st == 2'd0);

  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(first) |-> (first == $past(first) - 1'b1));

  a_r9_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (link_read && wcnt == WLAST) |=> st == 2'd0);
endmodule

bind spectro_scroll spectro_scroll_chk #(.COL_W(COL_W), .WCNT_W(WCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .link_valid(link_valid),
  .link_read(link_read), .st(st), .first(first), .wcnt(wcnt), .phase(phase)
);

// File: tb/sim_spectro_scroll.sv
`timescale 1ns/1ps
module sim_spectro_scroll;
  localparam int XW = 10, YW = 10, ACT_W = 640, ACT_H = 480, COLS = 8, ROWS = 128;
  localparam int WPC = ROWS / 4;

  logic clk = 0, rst_n = 0, frame_start = 0, link_valid = 0;
  logic [XW-1:0] px_x = '0;
  logic [YW-1:0] px_y = '0;
  logic [31:0] link_data = '0;
  logic link_read;
  logic [23:0] rgb;
  int checks = 0, errors = 0;
  int last_n = -1;

  always #10 clk = ~clk;

  spectro_scroll #(.XW(XW), .YW(YW), .ACT_W(ACT_W), .ACT_H(ACT_H), .COLS(COLS), .ROWS(ROWS)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .px_x(px_x), .px_y(px_y),
    .link_data(link_data), .link_valid(link_valid), .link_read(link_read), .rgb(rgb));

  function automatic logic [7:0] pix(int n, int row);
    return 8'((n * 37 + row * 5 + 11) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic probe(string req, int x, int y, logic [23:0] exp);
    @(negedge clk); px_x = XW'(x); px_y = YW'(y);
    @(negedge clk); check(req, rgb, exp);
  endtask

  task automatic start_frame();
    @(negedge clk); frame_start = 1; px_y = '0;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic end_frame();
    @(negedge clk); px_y = YW'(ACT_H);
    @(negedge clk); check("R5", rgb, 24'd0);
  endtask

  task automatic load_col(int n, bit stall);
    int k = 0, vcyc = 0, pops = 0, cyc = 0;
    while (k < WPC) begin
      bit pop;
      @(negedge clk);
      if (stall && cyc >= 9 && cyc < 15) begin
        link_valid = 0; link_data = 32'hDEAD_BEEF;
        #1 check("R7", link_read, 1'b0);
        pop = 0;
      end else begin
        link_valid = 1;
        link_data = {pix(n, 4*k+3), pix(n, 4*k+2), pix(n, 4*k+1), pix(n, 4*k)};
        #1 pop = link_read;
        vcyc++;
      end
      cyc++;
      @(posedge clk);
      if (pop) begin k++; pops++; end
      if (cyc > 1000) break;
    end
    @(negedge clk); link_valid = 0;
    check("R6", vcyc, ROWS);
    check("R6", pops, WPC);
    last_n = n;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", rgb, 24'd0);
    check("R1", link_read, 1'b0);
    rst_n = 1;
    probe("R2", 0, 0, 24'd0);
    probe("R2", 3, 7, 24'd0);
  endtask

  task automatic t_fill();
    for (int n = 0; n < COLS; n++) begin
      start_frame();
      end_frame();
      load_col(n, 0);
      probe("R9", 0, 0, 24'd0);
    end
  endtask

  task automatic t_draw();
    start_frame();
    for (int x = 0; x < COLS; x++) begin
      probe("R3", x, 0, {3{pix(last_n - x, 0)}});
      probe("R8", x, ROWS - 1, {3{pix(last_n - x, ROWS - 1)}});
    end
    for (int r = 1; r < 4; r++) probe("R6", 0, r, {3{pix(last_n, r)}});
    probe("R3", 2, 77, {3{pix(last_n - 2, 77)}});
    probe("R4", COLS, 5, 24'd0);
    probe("R4", 1, ROWS, 24'd0);
    probe("R4", ACT_W + 10, 5, 24'd0);
    end_frame();
  endtask

  task automatic t_stall_wrap();
    load_col(COLS, 1);
    probe("R9", 0, 0, 24'd0);
    start_frame();
    probe("R7", 0, 10, {3{pix(COLS, 10)}});
    probe("R7", 0, 45, {3{pix(COLS, 45)}});
    probe("R8", 1, 10, {3{pix(COLS - 1, 10)}});
    probe("R8", COLS - 1, 20, {3{pix(1, 20)}});
    end_frame();
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_draw();
    t_stall_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule